// File: doc/BRIEF.md
# Fractional-Predivide Clock Generator

This block derives a display-pixel or audio master clock from one of three source clocks. A two-step division produces the output. A predivide stage divides by 2, 2.5 or 3, and an integer stage divides its ticks by 2 to 127. The 2.5 step works by letting predivide ticks alternate between two and three source cycles. The integer stage keeps the output high for the larger half of its ticks and low for the smaller half, so duty stays as close to 50% as the tick count allows.

Software writes one 32-bit control word through a single-cycle write strobe in the system clock domain. The divider itself runs on the selected source clock. It takes a new setting only when an output period ends, and it takes the enable bit through a short synchronizer, so the output never shows a shortened pulse.

Top module: `clkgen_frac`

## Requirements
- R1: While reset is asserted and after it is released with no write, `clk_out` is low.
- R2: Control bit 14 clear selects `src_xtal`. Bit 14 set with bit 13 clear selects `src_pll_a`. Bits 14 and 13 both set select `src_pll_b`. All output timing is counted in cycles of the selected source.
- R3: Predivide code 1 in bits [9:8] makes each tick 2 source cycles, and code 3 makes it 3. With the integer divider N in bits [6:0], one output period lasts code-ratio × N source cycles.
- R4: Predivide code 2 makes ticks alternate between 2 and 3 source cycles across period boundaries, so any two consecutive output periods together last exactly 5 × N source cycles.
- R5: Each period is high for N − floor(N/2) ticks and then low for floor(N/2) ticks. With code 1 or 3, the high time is that tick count times 2 or 3 source cycles.
- R6: Predivide code 0, or N equal to 0 or 1, holds `clk_out` low while the enable bit is set.
- R7: A control write while the output runs leaves the current period to finish with its old timing. The new setting governs from the next period onward.
- R8: Clearing enable bit 15 drives `clk_out` low within 3 selected-source cycles, and it stays low. Setting the bit again starts with a complete high phase.
- R9: The shortest setting, code 1 with N = 2, gives an output period of 4 source cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Clock for the control register |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word: N [6:0], predivide code [9:8], PLL pick [13], PLL select [14], enable [15] |
| src_xtal | input | 1 | Crystal source clock |
| src_pll_a | input | 1 | First PLL source clock |
| src_pll_b | input | 1 | Second PLL source clock |
| clk_out | output | 1 | Divided, gated output clock |

## Verification
A control write can reach the divider in the same source cycle that closes an output period. In that cycle, the reload of the shadow setting competes with normal tick counting. The bench provokes this by writing a short setting partway through a long high phase. It judges the result by requiring that phase to keep its full old length and the following periods to take the new length. Disabling and period end can also coincide. They are judged by requiring a low output a few cycles after the disabling write, followed by a complete high phase once the block is re-enabled.

// File: rtl/clkgen_pkg.sv
`timescale 1ns/1ps
package clkgen_pkg;
  localparam int CFG_W    = 32;
  localparam int DIV_W    = 7;
  localparam int PRE_W    = 2;
  localparam int DIV_LSB  = 0;
  localparam int PRE_LSB  = 8;
  localparam int PICK_BIT = 13;
  localparam int SEL_BIT  = 14;
  localparam int EN_BIT   = 15;

  typedef enum logic [1:0] {SRC_XTAL = 2'd0, SRC_PLL_A = 2'd1, SRC_PLL_B = 2'd2} src_e;

  function automatic src_e pick_src(input logic pll_sel, input logic pll_pick);
    if (!pll_sel)     return SRC_XTAL;
    else if (!pll_pick) return SRC_PLL_A;
    else              return SRC_PLL_B;
  endfunction

  // source cycles in one predivide tick; phase chooses the long tick for code 2
  function automatic logic [1:0] tick_len(input logic [PRE_W-1:0] code, input logic phase);
    case (code)
      2'd1:    return 2'd2;
      2'd2:    return phase ? 2'd3 : 2'd2;
      2'd3:    return 2'd3;
      default: return 2'd2;
    endcase
  endfunction

  function automatic logic setting_ok(input logic [PRE_W-1:0] code, input logic [DIV_W-1:0] n);
    return (code != '0) && (n >= DIV_W'(2));
  endfunction

  function automatic logic [DIV_W-1:0] high_ticks(input logic [DIV_W-1:0] n);
    return n - (n >> 1);
  endfunction
endpackage

// File: rtl/clkgen_cfg_reg.sv
`timescale 1ns/1ps
module clkgen_cfg_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/clkgen_src_mux.sv
`timescale 1ns/1ps
module clkgen_src_mux
  import clkgen_pkg::*;
(
  input  logic pll_sel,
  input  logic pll_pick,
  input  logic src_xtal,
  input  logic src_pll_a,
  input  logic src_pll_b,
  output logic clk_sel
);
  src_e which;
  assign which = pick_src(pll_sel, pll_pick);
  always_comb begin
    case (which)
      SRC_PLL_A: clk_sel = src_pll_a;
      SRC_PLL_B: clk_sel = src_pll_b;
      default:   clk_sel = src_xtal;
    endcase
  end
endmodule

// File: rtl/clkgen_div_core.sv
`timescale 1ns/1ps
module clkgen_div_core
  import clkgen_pkg::*;
#(
  parameter int DW     = DIV_W,
  parameter int PW     = PRE_W,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_async,
  input  logic [PW-1:0] pre_in,
  input  logic [DW-1:0] div_in,
  output logic          clk_out,
  output logic          en_s,
  output logic          run_q,
  output logic          tick_end,
  output logic          per_end,
  output logic [1:0]    pcnt,
  output logic [DW-1:0] tcnt,
  output logic [PW-1:0] sh_pre,
  output logic [DW-1:0] sh_div
);
  logic [STAGES-1:0] sync_q;
  logic              alt_q;
  logic              out_q;
  logic              load_ok;
  logic [DW-1:0]     tcnt_inc;

  generate
    if (STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= en_async;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], en_async};
    end
  endgenerate

  assign en_s     = sync_q[STAGES-1];
  assign load_ok  = setting_ok(pre_in, div_in);
  assign tcnt_inc = tcnt + DW'(1);
  assign tick_end = run_q && (pcnt == tick_len(sh_pre, alt_q) - 2'd1);
  assign per_end  = tick_end && (tcnt == sh_div - DW'(1));
  assign clk_out  = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; sh_pre <= '0; sh_div <= '0;
      pcnt  <= '0;   tcnt   <= '0; alt_q  <= 1'b0; out_q <= 1'b0;
    end else if (!en_s) begin
      run_q <= 1'b0; sh_pre <= pre_in; sh_div <= div_in;
      pcnt  <= '0;   tcnt   <= '0;     alt_q  <= 1'b0; out_q <= 1'b0;
    end else if (!run_q || per_end) begin
      sh_pre <= pre_in;
      sh_div <= div_in;
      pcnt   <= '0;
      tcnt   <= '0;
      alt_q  <= run_q ? ~alt_q : 1'b0;
      run_q  <= load_ok;
      out_q  <= load_ok;
    end else if (tick_end) begin
      pcnt  <= '0;
      tcnt  <= tcnt_inc;
      alt_q <= ~alt_q;
      out_q <= (tcnt_inc < high_ticks(sh_div));
    end else begin
      pcnt <= pcnt + 2'd1;
    end
  end
endmodule

// File: rtl/clkgen_frac.sv
`timescale 1ns/1ps
module clkgen_frac
  import clkgen_pkg::*;
#(
  parameter int CW          = CFG_W,
  parameter int DIV_BITS    = DIV_W,
  parameter int PRE_BITS    = PRE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          sys_clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          src_xtal,
  input  logic          src_pll_a,
  input  logic          src_pll_b,
  output logic          clk_out
);
  logic [CW-1:0]       cfg_q;
  logic                sel_clk;
  logic                en_s, run_q, tick_end, per_end;
  logic [1:0]          pcnt;
  logic [DIV_BITS-1:0] tcnt, sh_div;
  logic [PRE_BITS-1:0] sh_pre;
  logic                unused_rsvd;

  assign unused_rsvd = ^cfg_q;

  clkgen_cfg_reg #(.W(CW)) u_cfg (
    .clk(sys_clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
  );

  clkgen_src_mux u_mux (
    .pll_sel(cfg_q[SEL_BIT]), .pll_pick(cfg_q[PICK_BIT]),
    .src_xtal(src_xtal), .src_pll_a(src_pll_a), .src_pll_b(src_pll_b),
    .clk_sel(sel_clk)
  );

  clkgen_div_core #(.DW(DIV_BITS), .PW(PRE_BITS), .STAGES(SYNC_STAGES)) u_core (
    .clk(sel_clk), .rst_n(rst_n), .en_async(cfg_q[EN_BIT]),
    .pre_in(cfg_q[PRE_LSB +: PRE_BITS]), .div_in(cfg_q[DIV_LSB +: DIV_BITS]),
    .clk_out(clk_out), .en_s(en_s), .run_q(run_q), .tick_end(tick_end),
    .per_end(per_end), .pcnt(pcnt), .tcnt(tcnt), .sh_pre(sh_pre), .sh_div(sh_div)
  );
endmodule

// File: rtl/clkgen_frac_chk.sv
`timescale 1ns/1ps
module clkgen_frac_chk #(
  parameter int DW = 7,
  parameter int PW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_s,
  input logic          run_q,
  input logic          tick_end,
  input logic          per_end,
  input logic [1:0]    pcnt,
  input logic [DW-1:0] tcnt,
  input logic [PW-1:0] sh_pre,
  input logic [DW-1:0] sh_div,
  input logic          clk_out
);
  // R7: the shadow setting changes only at a period end or while idle
  p_hold_mid_period_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && en_s && !per_end |=> $stable(sh_div) && $stable(sh_pre));
  // R8: a low synchronized enable forces the output low at the next edge
  p_gate_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !clk_out && !run_q);
  // R3 / R4: every tick ends after 2 or 3 source cycles
  p_tick_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_end |-> (pcnt == 2'd1 || pcnt == 2'd2));
  // R5: the output rises only at the first cycle of a period
  p_rise_at_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_out) |-> (tcnt == '0 && pcnt == 2'd0));
  // R6: a running divider always holds a usable setting
  p_valid_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (sh_pre != '0 && sh_div >= DW'(2)));
  // R3: tick index stays inside the period
  p_tick_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> tcnt < sh_div);
endmodule

bind clkgen_frac clkgen_frac_chk #(.DW(DIV_BITS), .PW(PRE_BITS)) u_chk (
  .clk(sel_clk), .rst_n(rst_n), .en_s(en_s), .run_q(run_q), .tick_end(tick_end),
  .per_end(per_end), .pcnt(pcnt), .tcnt(tcnt), .sh_pre(sh_pre), .sh_div(sh_div),
  .clk_out(clk_out)
);

// File: tb/sim_clkgen_frac.sv
`timescale 1ns/1ps
module sim_clkgen_frac;
  logic        sys_clk = 0, rst_n = 0, cfg_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic        xt = 0, pa = 0, pb = 0;
  logic        clk_out;
  int          b_src = 0;
  int          n_vec = 0, n_bad = 0;
  logic        mon_clk;

  always #2.5 sys_clk = ~sys_clk;
  always #7   xt = ~xt;
  always #3   pa = ~pa;
  always #5   pb = ~pb;
  assign mon_clk = (b_src == 0) ? xt : (b_src == 1) ? pa : pb;

  clkgen_frac u0 (.sys_clk(sys_clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .src_xtal(xt), .src_pll_a(pa), .src_pll_b(pb), .clk_out(clk_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input int src, input int pre, input int n, input bit en);
    logic [31:0] w = '0;
    w[6:0] = n[6:0];
    w[9:8] = pre[1:0];
    w[14]  = (src != 0);
    w[13]  = (src == 2);
    w[15]  = en;
    return w;
  endfunction

  task automatic wr(input logic [31:0] w);
    @(negedge sys_clk); cfg_we = 1; cfg_wdata = w;
    @(negedge sys_clk); cfg_we = 0;
  endtask

  task automatic start(input int src, input int pre, input int n);
    wr(word(src, pre, n, 0));
    b_src = src;
    repeat (8) @(negedge mon_clk);
    wr(word(src, pre, n, 1));
  endtask

  // pair: source cycles spanned by two periods; high: high cycles of the first
  task automatic measure(output int pair, output int high, output bit ok);
    int rises = 0, r0 = 0;
    bit prev = 0;
    ok = 0; pair = -1; high = -1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge mon_clk);
      if (clk_out && !prev) begin
        rises++;
        if (rises == 3) r0 = i;
        if (rises == 5) begin pair = i - r0; ok = 1; break; end
      end
      if (!clk_out && prev && rises == 3 && high < 0) high = i - r0;
      prev = clk_out;
    end
  endtask

  task automatic ones(input int cycles, output int cnt);
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge mon_clk);
      if (clk_out) cnt++;
    end
  endtask

  task automatic sweep_one(input int src, input int pre, input int n, input string req);
    int pair, high, exp_pair, cyc;
    bit ok;
    cyc = (pre == 1) ? 2 : 3;
    exp_pair = (pre == 1) ? 4 * n : (pre == 2) ? 5 * n : 6 * n;
    start(src, pre, n);
    measure(pair, high, ok);
    chk(ok && pair == exp_pair, req, pair, exp_pair);
    if (pre != 2) chk(high == cyc * (n - n / 2), "R5", high, cyc * (n - n / 2));
  endtask

  initial begin
    #900000;
    n_vec++; n_bad++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int cnt, h, pair, high;
    bit ok;
    repeat (4) @(negedge sys_clk);
    chk(clk_out == 0, "R1", clk_out, 0);
    rst_n = 1;
    repeat (40) @(negedge sys_clk);
    chk(clk_out == 0, "R1", clk_out, 0);

    // R3 R4 R5 sweep on the crystal source
    for (int pre = 1; pre <= 3; pre++) begin
      for (int n = 2; n <= 12; n++) sweep_one(0, pre, n, (pre == 2) ? "R4" : "R3");
      sweep_one(0, pre, 127, (pre == 2) ? "R4" : "R3");
    end

    // R2 source selection, R9 fastest setting on every source
    for (int s = 0; s < 3; s++) begin
      sweep_one(s, 1, 2, "R9");
      sweep_one(s, 2, 5, "R2");
      sweep_one(s, 3, 7, "R2");
    end

    // R6 unusable settings keep the output low
    start(0, 0, 5);  ones(300, cnt); chk(cnt == 0, "R6", cnt, 0);
    start(0, 1, 1);  ones(300, cnt); chk(cnt == 0, "R6", cnt, 0);
    start(1, 3, 0);  ones(300, cnt); chk(cnt == 0, "R6", cnt, 0);

    // R7 write mid high phase: old period completes, then new timing
    start(0, 3, 127);
    do @(negedge mon_clk); while (!clk_out);
    h = 1;
    fork
      begin
        for (int i = 0; i < 2000; i++) begin
          @(negedge mon_clk);
          if (clk_out) h++; else break;
        end
      end
      begin
        repeat (20) @(negedge mon_clk);
        wr(word(0, 1, 2, 1));
      end
    join
    chk(h == 192, "R7", h, 192);
    measure(pair, high, ok);
    chk(ok && pair == 8, "R7", pair, 8);

    // R8 disable then re-enable
    start(0, 1, 6);
    measure(pair, high, ok);
    wr(word(0, 1, 6, 0));
    repeat (5) @(negedge mon_clk);
    ones(200, cnt);
    chk(cnt == 0, "R8", cnt, 0);
    wr(word(0, 1, 6, 1));
    do @(negedge mon_clk); while (!clk_out);
    h = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge mon_clk);
      if (clk_out) h++; else break;
    end
    chk(h == 6, "R8", h, 6);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule